// File: doc/BRIEF.md
# Sparse Operation-Unit Matrix-Vector Multiply Engine

This block is a digital model of a weight crossbar that is worked through in small tiles. A 16 by 16 signed 8-bit weight matrix is split into a 4 by 4 grid of operation units (OUs). Each OU is 4 rows by 4 columns. When a pass is started, the engine computes the product of the stored matrix and a 16-element signed 8-bit activation vector. It gives 16 signed 24-bit column sums. In each cycle it evaluates at most one OU, so each cycle contributes no more than sixteen products.

Weights are written one OU row slice per beat, and they are stored compacted. Within each OU, a slice whose four weights are all zero is not stored. The remaining slices are packed towards slot 0, and each one keeps the 2-bit local row number it came from. That row number later selects the matching activation. Compaction acts on rows only, so every partial sum still lands on its own column.

During a pass, the engine moves to the next OU that is worth computing and spends no cycle on the others. An OU is passed over when its four activations are all zero or when it holds no stored slice. Visits go through the column groups in order, and within a column group through the row groups in order. A debug count reports how many OUs were actually computed.

Top module: `sparse_ou_mvm`

## Requirements
- R1: After reset the following hold. All OUs are empty. `y_out` is all zero. `done`, `busy` and `ou_count` are 0, and `wr_ready` is 1. A pass run before any weight write returns all-zero results and computes no OU.
- R2: A weight beat is taken on a clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 while a pass is running, and a beat offered then is not taken and does not change the stored weights. A beat is addressed by `wr_row` (logical row 0..15) and `wr_grp` (column group 0..3, covering columns 4g..4g+3). Weight c of the beat sits at `wr_data[8c+7:8c]` and belongs to column 4g+c.
- R3: A beat whose four weights are all zero is dropped from its OU. A beat with local row 0 (`wr_row` mod 4 = 0) discards everything previously stored for that OU and starts it afresh. Each OU's rows must therefore be written in ascending order, beginning at its local row 0.
- R4: A `start` pulse seen while idle captures `act_in` and clears `y_out` to zero. Activation i sits at `act_in[8i+7:8i]`. A `start` seen while a pass is running is ignored, and so is any change of `act_in` during the pass.
- R5: At the end of a pass, column c of `y_out` (bits [24c+23:24c]) holds the signed sum over r of W[r][c]·a[r].
- R6: An OU whose four activations are all zero, or which has no stored slice, is not computed and takes no cycle.
- R7: Let k be the number of OUs computed in a pass. `done` is a one-cycle pulse in the (k+2)-th cycle after the cycle in which `start` was applied. `busy` is 1 from the edge that took `start` until the edge that raises `done`.
- R8: `ou_count` equals k once a pass ends. It keeps that value until the next accepted `start`.
- R9: While the engine is idle and no `start` is applied, `y_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Weight beat offered |
| wr_ready | output | 1 | Engine can take a weight beat |
| wr_row | input | 4 | Logical weight row of the beat |
| wr_grp | input | 2 | Column group of the beat |
| wr_data | input | 32 | Four signed 8-bit weights, lane c = column 4g+c |
| start | input | 1 | Begin one multiply pass |
| act_in | input | 128 | Sixteen signed 8-bit activations |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| ou_count | output | 5 | OUs computed in the last pass |
| y_out | output | 384 | Sixteen signed 24-bit column results |

## Verification
The hardest situation to reach from the ports is a pass in which skipped and computed OUs alternate in uneven patterns. That needs control over sparsity both in the stored matrix and in the activation vector, and it is the only way to see whether a skip really costs no cycle. The bench combines five matrix styles with five activation styles: dense, slice-sparse, empty, extreme-valued and diagonal. It derives the expected column sums, the number of live OUs and the `done` cycle arithmetically. Separate cases repack a single OU through a row-0 restart, apply `start` and a weight beat while a pass is running, and then confirm that neither has any effect.

// File: rtl/sou_pkg.sv
package sou_pkg;
    localparam int ROWS  = 16;
    localparam int COLS  = 16;
    localparam int OU_R  = 4;
    localparam int OU_C  = 4;
    localparam int WW    = 8;
    localparam int AW    = 8;
    localparam int ACCW  = 24;

    localparam int N_RG  = ROWS / OU_R;
    localparam int N_CG  = COLS / OU_C;
    localparam int NOU   = N_RG * N_CG;
    localparam int ROWW  = $clog2(ROWS);
    localparam int LRW   = $clog2(OU_R);
    localparam int RGW   = $clog2(N_RG);
    localparam int CGW   = $clog2(N_CG);
    localparam int OUW   = $clog2(NOU);
    localparam int CNTW  = $clog2(OU_R + 1);
    localparam int OCW   = $clog2(NOU + 1);

    typedef logic signed [WW-1:0]   wt_t;
    typedef logic signed [AW-1:0]   act_t;
    typedef logic signed [ACCW-1:0] acc_t;
    typedef logic [OU_C*WW-1:0]     wbeat_t;

    typedef enum logic {ST_IDLE, ST_RUN} sched_st_e;

    // OU index layout: column group in the high bits gives column-group-major order
    typedef struct packed {
        logic [CGW-1:0] cg;
        logic [RGW-1:0] rg;
    } ou_pos_t;

    function automatic wt_t lane_w(wbeat_t b, int c);
        return wt_t'(b[c*WW +: WW]);
    endfunction

    function automatic acc_t mul_ext(wt_t w, act_t a);
        logic signed [WW+AW-1:0] p;
        p = w * a;
        return acc_t'(p);
    endfunction
endpackage

// File: rtl/sou_wstore.sv
module sou_wstore
    import sou_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_fire,
    input  logic [ROWW-1:0] wr_row,
    input  logic [CGW-1:0]  wr_grp,
    input  wbeat_t          wr_data,
    input  logic [OUW-1:0]  rd_ou,
    output wbeat_t          rd_w   [OU_R],
    output logic [LRW-1:0]  rd_idx [OU_R],
    output logic [CNTW-1:0] rd_cnt,
    output logic [NOU-1:0]  ou_empty
);
    wbeat_t          w_mem [NOU][OU_R];
    logic [LRW-1:0]  i_mem [NOU][OU_R];
    logic [CNTW-1:0] cnt_q [NOU];

    ou_pos_t         wpos;
    logic [OUW-1:0]  wr_ou;
    logic [LRW-1:0]  lr;
    logic            nz;
    logic [CNTW-1:0] slot;

    always_comb begin
        wpos.cg = wr_grp;
        wpos.rg = wr_row[ROWW-1:LRW];
        wr_ou   = wpos;
        lr      = wr_row[LRW-1:0];
        nz      = |wr_data;
        slot    = (lr == '0) ? '0 : cnt_q[wr_ou];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NOU; i++) cnt_q[i] <= '0;
        end else if (wr_fire) begin
            if (lr == '0)
                cnt_q[wr_ou] <= CNTW'(nz);
            else if (nz && cnt_q[wr_ou] < CNTW'(OU_R))
                cnt_q[wr_ou] <= cnt_q[wr_ou] + CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire && nz && slot < CNTW'(OU_R)) begin
            w_mem[wr_ou][slot[LRW-1:0]] <= wr_data;
            i_mem[wr_ou][slot[LRW-1:0]] <= lr;
        end
    end

    always_comb begin
        for (int s = 0; s < OU_R; s++) begin
            rd_w[s]   = w_mem[rd_ou][s];
            rd_idx[s] = i_mem[rd_ou][s];
        end
        rd_cnt = cnt_q[rd_ou];
    end

    for (genvar i = 0; i < NOU; i++) begin : g_empty
        assign ou_empty[i] = (cnt_q[i] == '0);
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            cnt_q[i] <= CNTW'(OU_R)); // R3
    end

    AST_ROW0_RESTART: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && lr == '0 && !nz) |=> ou_empty[$past(wr_ou)]); // R3
endmodule

// File: rtl/sou_mac.sv
module sou_mac
    import sou_pkg::*;
(
    input  wbeat_t          w_rows [OU_R],
    input  logic [LRW-1:0]  idx    [OU_R],
    input  logic [CNTW-1:0] cnt,
    input  act_t            acts   [OU_R],
    output acc_t            part   [OU_C]
);
    always_comb begin
        acc_t sum;
        for (int c = 0; c < OU_C; c++) begin
            sum = '0;
            for (int r = 0; r < OU_R; r++) begin
                if (r < int'(cnt))
                    sum = sum + mul_ext(lane_w(w_rows[r], c), acts[idx[r]]);
            end
            part[c] = sum;
        end
    end
endmodule

// File: rtl/sou_sched.sv
module sou_sched
    import sou_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NOU-1:0]  ou_empty,
    input  logic [N_RG-1:0] grp_live,
    output logic            capture,
    output logic            fire,
    output logic [OUW-1:0]  sel,
    output logic            busy,
    output logic            done,
    output logic [OCW-1:0]  ou_count
);
    sched_st_e      state_q;
    logic [OUW:0]   ptr_q;
    logic [OCW-1:0] cnt_q;
    logic           done_q;
    logic           found;

    // lowest-index OU at or after the pointer that is worth computing
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NOU - 1; i >= 0; i--) begin
            if (!ou_empty[i] && grp_live[i % N_RG] && (OUW+1)'(i) >= ptr_q) begin
                found = 1'b1;
                sel   = OUW'(i);
            end
        end
    end

    assign capture  = (state_q == ST_IDLE) && start;
    assign fire     = (state_q == ST_RUN) && found;
    assign busy     = (state_q == ST_RUN);
    assign done     = done_q;
    assign ou_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    ptr_q   <= '0;
                    cnt_q   <= '0;
                end
                ST_RUN: if (found) begin
                    ptr_q <= (OUW+1)'(sel) + (OUW+1)'(1);
                    cnt_q <= cnt_q + OCW'(1);
                end else begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ou_count <= OCW'(NOU)); // R8
    AST_FIRE_FORWARD: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!fire || sel > $past(sel))); // R6
endmodule

// File: rtl/sparse_ou_mvm.sv
module sparse_ou_mvm
    import sou_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [ROWW-1:0]      wr_row,
    input  logic [CGW-1:0]       wr_grp,
    input  logic [OU_C*WW-1:0]   wr_data,
    input  logic                 start,
    input  logic [ROWS*AW-1:0]   act_in,
    output logic                 busy,
    output logic                 done,
    output logic [OCW-1:0]       ou_count,
    output logic [COLS*ACCW-1:0] y_out
);
    act_t            act_q  [ROWS];
    acc_t            acc_q  [COLS];
    logic [N_RG-1:0] grp_live;
    logic [NOU-1:0]  ou_empty;
    logic            capture, fire;
    logic [OUW-1:0]  sel;
    ou_pos_t         pos;
    wbeat_t          rd_w   [OU_R];
    logic [LRW-1:0]  rd_idx [OU_R];
    logic [CNTW-1:0] rd_cnt;
    act_t            ou_acts [OU_R];
    acc_t            part    [OU_C];

    assign wr_ready = !busy;
    assign pos      = ou_pos_t'(sel);

    always_comb begin
        for (int g = 0; g < N_RG; g++) begin
            grp_live[g] = 1'b0;
            for (int r = 0; r < OU_R; r++)
                if (act_q[g*OU_R + r] != '0) grp_live[g] = 1'b1;
        end
        for (int r = 0; r < OU_R; r++)
            ou_acts[r] = act_q[int'(pos.rg)*OU_R + r];
    end

    sou_wstore u_store (
        .clk(clk), .rst(rst),
        .wr_fire(wr_valid && wr_ready),
        .wr_row(wr_row), .wr_grp(wr_grp), .wr_data(wr_data),
        .rd_ou(sel), .rd_w(rd_w), .rd_idx(rd_idx), .rd_cnt(rd_cnt),
        .ou_empty(ou_empty)
    );

    sou_sched u_sched (
        .clk(clk), .rst(rst), .start(start),
        .ou_empty(ou_empty), .grp_live(grp_live),
        .capture(capture), .fire(fire), .sel(sel),
        .busy(busy), .done(done), .ou_count(ou_count)
    );

    sou_mac u_mac (
        .w_rows(rd_w), .idx(rd_idx), .cnt(rd_cnt),
        .acts(ou_acts), .part(part)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) act_q[i] <= '0;
            for (int c = 0; c < COLS; c++) acc_q[c] <= '0;
        end else if (capture) begin
            for (int i = 0; i < ROWS; i++) act_q[i] <= act_t'(act_in[i*AW +: AW]);
            for (int c = 0; c < COLS; c++) acc_q[c] <= '0;
        end else if (fire) begin
            for (int c = 0; c < OU_C; c++)
                acc_q[int'(pos.cg)*OU_C + c] <= acc_q[int'(pos.cg)*OU_C + c] + part[c];
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_out
        assign y_out[c*ACCW +: ACCW] = acc_q[c];
    end

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(y_out)); // R9
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        capture |=> (y_out == '0)); // R4
    AST_FIRED_OU_LIVE: assert property (@(posedge clk) disable iff (rst)
        fire |-> (!ou_empty[sel] && grp_live[pos.rg])); // R6
endmodule

// File: tb/sparse_ou_mvm_tb.sv
`timescale 1ns/1ps
module sparse_ou_mvm_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         wr_valid;
    logic         wr_ready;
    logic [3:0]   wr_row;
    logic [1:0]   wr_grp;
    logic [31:0]  wr_data;
    logic         start;
    logic [127:0] act_in;
    logic         busy, done;
    logic [4:0]   ou_count;
    logic [383:0] y_out;

    always #2 clk = ~clk;

    sparse_ou_mvm u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_row(wr_row), .wr_grp(wr_grp), .wr_data(wr_data), .start(start),
        .act_in(act_in), .busy(busy), .done(done), .ou_count(ou_count),
        .y_out(y_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    int unsigned seed = 32'h1234_5678;
    int W [16][16];
    int a [16];
    int exp_y [16];
    int exp_k;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd8();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed[23:16]) - 128;
    endfunction

    function automatic int ycol(int c);
        return int'($signed(y_out[c*24 +: 24]));
    endfunction

    task automatic gen_w(int mode);
        for (int r = 0; r < 16; r++)
            for (int g = 0; g < 4; g++) begin
                bit zs = (mode == 1) && (rnd8() > 0);
                for (int c = g*4; c < g*4 + 4; c++)
                    case (mode)
                        0: W[r][c] = rnd8();
                        1: W[r][c] = zs ? 0 : rnd8();
                        2: W[r][c] = 0;
                        3: W[r][c] = -128;
                        default: W[r][c] = (r == c) ? r + 1 : 0;
                    endcase
            end
    endtask

    task automatic gen_a(int mode, int sel);
        for (int g = 0; g < 4; g++) begin
            bit zg = (mode == 3) && (rnd8() > 0);
            for (int r = g*4; r < g*4 + 4; r++)
                case (mode)
                    0: a[r] = 0;
                    1: a[r] = rnd8();
                    2: a[r] = (g == sel % 4) ? rnd8() : 0;
                    3: a[r] = zg ? 0 : rnd8();
                    default: a[r] = -128;
                endcase
        end
    endtask

    task automatic compute_exp();
        exp_k = 0;
        for (int c = 0; c < 16; c++) begin
            exp_y[c] = 0;
            for (int r = 0; r < 16; r++) exp_y[c] += W[r][c] * a[r];
        end
        for (int g = 0; g < 4; g++)
            for (int rg = 0; rg < 4; rg++) begin
                bit lw = 0, la = 0;
                for (int r = rg*4; r < rg*4 + 4; r++) begin
                    if (a[r] != 0) la = 1;
                    for (int c = g*4; c < g*4 + 4; c++)
                        if (W[r][c] != 0) lw = 1;
                end
                if (lw && la) exp_k++;
            end
    endtask

    task automatic wbeat(int r, int g);
        logic [31:0] d;
        for (int c = 0; c < 4; c++) d[c*8 +: 8] = 8'(W[r][g*4 + c]);
        wr_valid = 1'b1; wr_row = 4'(r); wr_grp = 2'(g); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic load_matrix();
        for (int g = 0; g < 4; g++)
            for (int r = 0; r < 16; r++) wbeat(r, g);
    endtask

    task automatic drive_acts();
        for (int i = 0; i < 16; i++) act_in[i*8 +: 8] = 8'(a[i]);
    endtask

    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_result(string tag);
        for (int c = 0; c < 16; c++)
            chk(ycol(c) == exp_y[c], {"R5 ", tag}, ycol(c), exp_y[c]);
        chk(int'(ou_count) == exp_k, {"R8 R6 ", tag}, ou_count, exp_k);
    endtask

    task automatic run_pass(string tag);
        int n;
        compute_exp();
        drive_acts();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && wr_ready == 1'b0, {"R2 R7 busy ", tag}, {busy, wr_ready}, 2);
        wait_done(n);
        chk(n == exp_k + 2, {"R7 R6 latency ", tag}, n, exp_k + 2);
        check_result(tag);
        for (int i = 0; i < 16; i++) act_in[i*8 +: 8] = 8'(rnd8());
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, {"R7 pulse ", tag}, done, 0);
        repeat (2) @(negedge clk);
        for (int c = 0; c < 16; c++)
            if (ycol(c) != exp_y[c]) chk(1'b0, {"R9 hold ", tag}, ycol(c), exp_y[c]);
        chk(int'(ou_count) == exp_k, {"R8 hold ", tag}, ou_count, exp_k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        int sa [16];
        rst = 1'b1; wr_valid = 1'b0; wr_row = '0; wr_grp = '0; wr_data = '0;
        start = 1'b0; act_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(y_out == '0, "R1 y zero", 0, 0);
        chk(done == 0 && busy == 0, "R1 done/busy", {done, busy}, 0);
        chk(ou_count == 0, "R1 ou_count", ou_count, 0);
        chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
        gen_w(2);
        gen_a(1, 0);
        run_pass("R1 empty store");

        // sweep of matrix and activation styles
        for (int wm = 0; wm < 5; wm++) begin
            gen_w(wm);
            load_matrix();
            for (int am = 0; am < 5; am++) begin
                gen_a(am, wm + am);
                run_pass($sformatf("sweep w%0d a%0d", wm, am));
            end
        end

        // R3: repack one OU through a row-0 restart
        gen_w(0);
        load_matrix();
        for (int c = 0; c < 4; c++) begin
            W[0][c] = c + 1; W[1][c] = 0; W[2][c] = -7 * (c + 1); W[3][c] = 0;
        end
        W[0][0] = 0; W[0][1] = 0; W[0][2] = 0; W[0][3] = 0;
        W[1][2] = 5;
        for (int r = 0; r < 4; r++) wbeat(r, 0);
        for (int i = 0; i < 16; i++) a[i] = i - 8 + ((i == 8) ? 3 : 0);
        run_pass("R3 repack");
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) W[r][c] = 0;
        for (int r = 0; r < 4; r++) wbeat(r, 0);
        run_pass("R3 emptied OU");

        // R4/R2: start and a weight beat while busy are ignored
        gen_w(0);
        load_matrix();
        gen_a(1, 0);
        a[0] = 9;
        for (int i = 0; i < 16; i++) sa[i] = a[i];
        compute_exp();
        drive_acts();
        start = 1'b1;
        @(negedge clk);
        chk(wr_ready == 1'b0, "R2 ready low while busy", wr_ready, 0);
        for (int i = 0; i < 16; i++) act_in[i*8 +: 8] = 8'(rnd8());
        wr_valid = 1'b1; wr_row = 4'd0; wr_grp = 2'd0; wr_data = 32'd0;
        @(negedge clk);
        start = 1'b0; wr_valid = 1'b0;
        n = 2;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_k + 2, "R4 latency with second start", n, exp_k + 2);
        check_result("R4 second start ignored");
        @(negedge clk);
        for (int i = 0; i < 16; i++) a[i] = sa[i];
        run_pass("R2 store untouched by busy beat");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule